// File: doc/BRIEF.md
# Configuration Load Checksum Verifier

This block sits beside a boot-time configuration loader and watches every byte that the loader takes from a serial EEPROM. It keeps a running 8-bit sum over each byte that is processed. This includes the bytes of jump blocks, whether or not the jump is taken. Bytes that a taken jump skips are never presented to the block, so they never enter the sum. The load ends with a two-byte terminator. The first byte is a type byte. The second byte is a checksum chosen so that the sum of all processed bytes, terminator included, is all ones.

A one-cycle start pulse arms the block. The block then rejects the load if the terminator is malformed, if the final sum is wrong, or if the loader signals an external fault. Any of these raises a sticky error flag and a sticky halt request, and ends the load. A done flag marks the end of the load, whether it ended normally or was aborted. For debugging, the block keeps the first three bytes of the most recent block that finished normally.

The loader marks the first byte of each block with a block-start strobe, and marks both terminator bytes with a terminator strobe. A block counts as finished normally when the next block start is accepted. The terminator block itself is never logged.

Top module: `cfg_csum_verifier`

## Requirements
- R1: After reset, err_o, done_o and halt_o are 0 and hdr_log_o is 0.
- R2: A byte is accepted only while a load is running, byte_vld_i is 1, and start_i and ext_err_i are both 0. Accepted bytes are summed modulo 256, starting from zero and including both terminator bytes. If the sum is 0xFF after the second terminator byte, done_o is 1 and err_o and halt_o stay 0 from the next cycle.
- R3: If the sum after the second terminator byte is not 0xFF and ign_csum_i is 0, then err_o, halt_o and done_o are all 1 from the next cycle.
- R4: If ign_csum_i is 1 while the second terminator byte is accepted, a wrong sum still sets done_o, but err_o and halt_o stay 0.
- R5: The first terminator byte must be exactly 0x07, meaning the type field in bits [2:0] is 3'b111 and the reserved bits [7:3] are zero. Any other value sets err_o, halt_o and done_o in the next cycle, whatever ign_csum_i is.
- R6: ext_err_i during a running load sets err_o, halt_o and done_o in the next cycle. A byte offered in that same cycle is not accepted.
- R7: Once done_o is 1, bytes and errors have no effect on any output until the next start pulse.
- R8: start_i ends any load, clears err_o, done_o, halt_o, the sum and the staged header bytes, and starts a new load. hdr_log_o keeps its value. A byte offered with start_i is dropped.
- R9: When a block-start byte is accepted and an earlier block was staged, hdr_log_o takes that earlier block's first three bytes. The first byte goes in bits [7:0], the second in [15:8] and the third in [23:16]. Missing bytes of a shorter block read as zero.
- R10: Before the first start pulse after reset, no byte or error has any effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous pulse that starts a new load |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Byte read by the loader |
| blk_start_i | input | 1 | Marks the first byte of a block |
| done_seq_i | input | 1 | Marks a byte of the two-byte terminator |
| ext_err_i | input | 1 | External fault raised by the loader |
| ign_csum_i | input | 1 | Suppress checksum mismatch errors |
| err_o | output | 1 | Sticky error flag |
| done_o | output | 1 | Load finished or aborted |
| halt_o | output | 1 | Sticky halt request |
| hdr_log_o | output | 24 | First three bytes of the last normally finished block |

## Verification
An external fault can arrive in the same cycle as a block-start byte, and those two events conflict. The bench provokes this in the middle of a load, after one block has already been committed to the log. It then checks that the log still holds that first block, not the block whose end the dropped byte would have marked, and that the error, halt and done flags all rise together one cycle later. A second coincidence is checked as well: a malformed first terminator byte that also acts as a block start. In that case the block before it is still committed.

// File: rtl/cfg_csum_pkg.sv
package cfg_csum_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned LOG_B    = 3;
  localparam int unsigned TYPE_W   = 3;
  localparam logic [TYPE_W-1:0] DONE_TYPE = '1;
  localparam logic [DW-1:0]     SUM_GOOD  = '1;
  typedef logic [DW-1:0] byte_t;
endpackage

// File: rtl/cfg_csum_acc.sv
module cfg_csum_acc #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] sum_nxt_o
);
  logic [DW-1:0] sum_q;

  assign sum_nxt_o = sum_q + byte_i;  // carry out of the top bit dropped

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_nxt_o;
  end
endmodule

// File: rtl/cfg_hdr_stage.sv
module cfg_hdr_stage #(
  parameter int unsigned DW = 8,
  parameter int unsigned NB = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             first_i,
  input  logic [DW-1:0]    byte_i,
  output logic [NB*DW-1:0] log_o
);
  localparam int unsigned IW = $clog2(NB + 1);

  logic [DW-1:0]    slot_q [NB];
  logic [NB*DW-1:0] stage_w;
  logic [NB*DW-1:0] log_q;
  logic [IW-1:0]    idx_q;
  logic             stg_vld_q;

  for (genvar g = 0; g < NB; g++) begin : g_slot
    assign stage_w[g*DW +: DW] = slot_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slot_q[g] <= '0;
      else if (clr_i)   slot_q[g] <= '0;
      else if (first_i) slot_q[g] <= (g == 0) ? byte_i : '0;
      else if (push_i && stg_vld_q && (idx_q == IW'(g))) slot_q[g] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      stg_vld_q <= 1'b0;
      log_q     <= '0;
    end else if (clr_i) begin
      idx_q     <= '0;
      stg_vld_q <= 1'b0;
    end else if (first_i) begin
      if (stg_vld_q) log_q <= stage_w;
      idx_q     <= IW'(1);
      stg_vld_q <= 1'b1;
    end else if (push_i && stg_vld_q && (idx_q < IW'(NB))) begin
      idx_q <= idx_q + IW'(1);
    end
  end

  assign log_o = log_q;
endmodule

// File: rtl/cfg_done_check.sv
module cfg_done_check #(
  parameter int unsigned           DW     = 8,
  parameter int unsigned           TYPE_W = 3,
  parameter logic [TYPE_W-1:0]     TYPE_V = '1
) (
  input  logic [DW-1:0] byte_i,
  output logic          fmt_ok_o
);
  // type in the low bits, all reserved bits above must be zero
  assign fmt_ok_o = (byte_i[TYPE_W-1:0] == TYPE_V) && (byte_i[DW-1:TYPE_W] == '0);
endmodule

// File: rtl/cfg_csum_verifier.sv
module cfg_csum_verifier
  import cfg_csum_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [DW-1:0]     byte_i,
  input  logic              blk_start_i,
  input  logic              done_seq_i,
  input  logic              ext_err_i,
  input  logic              ign_csum_i,
  output logic              err_o,
  output logic              done_o,
  output logic              halt_o,
  output logic [LOG_B*DW-1:0] hdr_log_o
);
  logic  run_q, dph_q, err_q, done_q, halt_q;
  logic  acc, ext_hit, dbyte0, dbyte1, fmt_ok, fmt_bad, sum_bad, fail, finish;
  byte_t sum_nxt;

  assign acc     = run_q && byte_vld_i && !start_i && !ext_err_i;
  assign ext_hit = run_q && ext_err_i && !start_i;
  assign dbyte0  = acc && done_seq_i && !dph_q;
  assign dbyte1  = acc && done_seq_i && dph_q;
  assign fmt_bad = dbyte0 && !fmt_ok;
  assign sum_bad = dbyte1 && (sum_nxt != SUM_GOOD) && !ign_csum_i;
  assign fail    = ext_hit || fmt_bad || sum_bad;
  assign finish  = fail || dbyte1;

  cfg_csum_acc #(.DW(DW)) u_acc (
    .clk_i, .rst_ni,
    .clr_i     (start_i),
    .add_i     (acc),
    .byte_i    (byte_i),
    .sum_nxt_o (sum_nxt)
  );

  cfg_done_check #(.DW(DW), .TYPE_W(TYPE_W), .TYPE_V(DONE_TYPE)) u_chk_fmt (
    .byte_i   (byte_i),
    .fmt_ok_o (fmt_ok)
  );

  cfg_hdr_stage #(.DW(DW), .NB(LOG_B)) u_stage (
    .clk_i, .rst_ni,
    .clr_i   (start_i),
    .push_i  (acc),
    .first_i (acc && blk_start_i),
    .byte_i  (byte_i),
    .log_o   (hdr_log_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; dph_q <= 1'b0;
      err_q <= 1'b0; done_q <= 1'b0; halt_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1; dph_q <= 1'b0;
      err_q <= 1'b0; done_q <= 1'b0; halt_q <= 1'b0;
    end else begin
      if (dbyte0 && fmt_ok) dph_q <= 1'b1;
      if (fail) begin
        err_q  <= 1'b1;
        halt_q <= 1'b1;
      end
      if (finish) begin
        done_q <= 1'b1;
        run_q  <= 1'b0;
      end
    end
  end

  assign err_o  = err_q;
  assign done_o = done_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/cfg_csum_verifier_chk.sv
module cfg_csum_verifier_chk #(
  parameter int unsigned LW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ext_err_i,
  input logic          run_i,
  input logic          err_i,
  input logic          done_i,
  input logic          halt_i,
  input logic [LW-1:0] log_i
);
  p_halt_with_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> err_i);
  p_err_ends_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> done_i);
  p_ext_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_err_i && run_i && !start_i) |=> (err_i && halt_i && done_i));
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !start_i) |=> err_i);
  p_log_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> $stable(log_i));
  p_start_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!err_i && !done_i && !halt_i && run_i));
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !done_i && !start_i) |=> ($stable(log_i) && !err_i));
endmodule

bind cfg_csum_verifier cfg_csum_verifier_chk #(.LW(24)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ext_err_i (ext_err_i),
  .run_i     (run_q),
  .err_i     (err_o),
  .done_i    (done_o),
  .halt_i    (halt_o),
  .log_i     (hdr_log_o)
);

// File: tb/cfg_csum_verifier_test.sv
module cfg_csum_verifier_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, bvld = 1'b0, blk = 1'b0, dseq = 1'b0, exterr = 1'b0, ign = 1'b0;
  logic [7:0]  bdat = '0;
  logic        err, done, halt;
  logic [23:0] hlog;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #5ns clk = ~clk;

  cfg_csum_verifier uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_vld_i(bvld), .byte_i(bdat),
    .blk_start_i(blk), .done_seq_i(dseq), .ext_err_i(exterr), .ign_csum_i(ign),
    .err_o(err), .done_o(done), .halt_o(halt), .hdr_log_o(hlog)
  );

  typedef struct packed {
    logic [7:0] seed;
    logic [1:0] nblk;
    logic [2:0] blen;
    logic [7:0] delta;
    logic       ign;
    logic       exp_err;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'h10, 2'd1, 3'd4, 8'h00, 1'b0, 1'b0},
    '{8'hA5, 2'd3, 3'd2, 8'h00, 1'b0, 1'b0},
    '{8'h3C, 2'd2, 3'd1, 8'h01, 1'b0, 1'b1},
    '{8'hF0, 2'd2, 3'd5, 8'h80, 1'b1, 1'b0},
    '{8'h77, 2'd3, 3'd3, 8'hFF, 1'b0, 1'b1},
    '{8'h01, 2'd1, 3'd3, 8'h00, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, hold across one rising edge, release
  task automatic put(logic [7:0] d, logic b, logic ds, logic xe = 1'b0);
    bdat = d; blk = b; dseq = ds; bvld = 1'b1; exterr = xe;
    @(negedge clk);
    bvld = 1'b0; blk = 1'b0; dseq = 1'b0; exterr = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog all-reqs act=hung exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", {29'd0, err, done, halt}, 32'd0);
    check("R1 log", {8'd0, hlog}, 32'd0);

    // R10 traffic before any start is ignored
    put(8'h11, 1, 0); put(8'h22, 0, 0); put(8'h33, 1, 0); put(8'h07, 1, 1);
    exterr = 1'b1; @(negedge clk); exterr = 1'b0;
    check("R10 log idle", {8'd0, hlog}, 32'd0);
    check("R10 flags idle", {29'd0, err, done, halt}, 32'd0);

    // vector table: R2 R3 R4 R8 R9
    foreach (VEC[i]) begin
      automatic logic [7:0]  sum = 8'd0;
      automatic logic [23:0] exp_log = 24'd0;
      automatic logic [7:0]  ck;
      ign = VEC[i].ign;
      pulse_start();
      check("R8 start clears", {29'd0, err, done, halt}, 32'd0);
      for (int b = 0; b < int'(VEC[i].nblk); b++) begin
        exp_log = 24'd0;
        for (int k = 0; k < int'(VEC[i].blen); k++) begin
          automatic logic [7:0] d = 8'(int'(VEC[i].seed) + 37 * k + 11 * b);
          put(d, k == 0, 0);
          sum += d;
          if (k < 3) exp_log[k*8 +: 8] = d;
        end
      end
      put(8'h07, 1, 1);
      sum += 8'h07;
      ck = 8'(8'hFF - sum) + VEC[i].delta;
      put(ck, 0, 1);
      check($sformatf("R2/R3/R4 v%0d err", i), {31'd0, err}, {31'd0, VEC[i].exp_err});
      check($sformatf("R3 v%0d halt", i), {31'd0, halt}, {31'd0, VEC[i].exp_err});
      check($sformatf("R2 v%0d done", i), {31'd0, done}, 32'd1);
      check($sformatf("R9 v%0d log", i), {8'd0, hlog}, {8'd0, exp_log});
    end
    ign = 1'b0;

    // R7 after done, bytes and errors ignored
    keep = hlog;
    put(8'h5A, 1, 0); put(8'h6B, 1, 0); put(8'h00, 1, 1, 1'b1);
    check("R7 log frozen", {8'd0, hlog}, {8'd0, keep});
    check("R7 flags frozen", {29'd0, err, done, halt}, 32'b010);

    // R8 start keeps log
    pulse_start();
    check("R8 log kept", {8'd0, hlog}, {8'd0, keep});
    check("R8 flags clear", {29'd0, err, done, halt}, 32'd0);

    // R6 ext err coincident with block start: byte dropped, no commit
    put(8'hA1, 1, 0); put(8'hA2, 0, 0); put(8'hA3, 0, 0); put(8'hA4, 0, 0);
    put(8'hB1, 1, 0);
    check("R9 commit A", {8'd0, hlog}, 32'h00A3A2A1);
    put(8'hB2, 0, 0);
    put(8'hC1, 1, 0, 1'b1);
    check("R6 log not committed", {8'd0, hlog}, 32'h00A3A2A1);
    check("R6 flags", {29'd0, err, done, halt}, 32'b111);

    // R5 bad reserved bits, ign set; prior block still committed
    ign = 1'b1;
    pulse_start();
    put(8'hD1, 1, 0); put(8'hD2, 0, 0);
    put(8'h0F, 1, 1);
    check("R5 reserved flags", {29'd0, err, done, halt}, 32'b111);
    check("R5 prior commit", {8'd0, hlog}, 32'h0000D2D1);
    ign = 1'b0;

    // R5 wrong type value
    pulse_start();
    put(8'hE1, 1, 0);
    put(8'h06, 1, 1);
    check("R5 type flags", {29'd0, err, done, halt}, 32'b111);

    // R8 byte with start dropped: clean load of only the terminator
    start = 1'b1; bvld = 1'b1; bdat = 8'h40; blk = 1'b1;
    @(negedge clk);
    start = 1'b0; bvld = 1'b0; blk = 1'b0;
    put(8'h07, 1, 1); put(8'hF8, 0, 1);
    check("R8 dropped byte", {29'd0, err, done, halt}, 32'b010);
    check("R8 no stage from dropped", {8'd0, hlog}, 32'h0000E1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule